// File: doc/BRIEF.md
# UART Receive Buffer with Per-Byte Status Readback

This block sits between a UART bit-level receiver and a processor's register read path. Each byte the receiver delivers is stored together with three reception flags: break, framing error and parity error. The processor pulls data bytes out one at a time with a read strobe. Each data read also produces an encoded status byte for the returned byte, and that status byte is appended to a second buffer. The processor can drain that buffer afterwards, in the same order as the data was read.

A run of data reads with no status read between them forms a burst. The first data read of a new burst throws away whatever the status buffer still holds. After a burst, the buffer therefore describes only the bytes that were just read. A single summary flag lets the processor skip the status readback when every byte of the burst arrived cleanly.

Reads of an empty data buffer are legal. They return 0x00 and yield a status byte that marks the byte as not received. Writes that arrive while the data buffer is full are discarded, and a sticky flag records the loss.

Top module: `uart_rx_stat_fifo`

## Requirements
- R1: The status byte has the following layout. Bits 7:5 read as 0. Bit 4 is break, bit 3 is framing error and bit 2 is parity error. Bit 1 means no data received. Bit 0 means no error. Bit 0 is 1 exactly when bits 4:1 are all 0. For example, a byte with both parity and framing errors gives 0x0C.
- R2: A byte written with `wr_brk`=1 is stored as 0x00, whatever `wr_byte` holds, and its status byte is 0x10.
- R3: A data read while the data buffer is empty returns `rd_data`=0x00 and loads status 0x02.
- R4: The data buffer returns bytes first-in first-out and holds 16 of them. A write while 16 bytes are held is discarded. A discarded write sets `overflow`, which then stays 1 until reset.
- R5: Each data read appends the status byte of the returned byte to the status buffer. The status buffer holds 16 entries, and a load into a full status buffer is dropped. Status reads return the entries in load order. `rd_data` and `rd_stat` take their new value at the clock edge that samples the strobe, and hold it otherwise.
- R6: The first data read after reset, or after any status read, empties the status buffer before it loads its own entry. If a data read and a status read arrive in the same cycle, `rd_stat` returns the old head entry, and the data read then starts a new burst.
- R7: A status read while the status buffer is empty returns `rd_stat`=0x00.
- R8: `any_bad` is 1 when any data read since the last status-buffer clear produced a status byte with bit 0 equal to 0. This includes a read whose load was dropped. It clears together with the status buffer, and status reads leave it unchanged.
- R9: An active-low reset empties both buffers and sets `rd_data`, `rd_stat`, `any_bad` and `overflow` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Receiver delivers a byte this cycle |
| wr_byte | input | 8 | Received data byte |
| wr_brk | input | 1 | Byte was a break condition |
| wr_fe | input | 1 | Byte had a framing (stop bit) error |
| wr_par | input | 1 | Byte had a parity error |
| rd_data_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Last data byte read |
| rd_stat_en | input | 1 | Status read strobe |
| rd_stat | output | 8 | Last status byte read |
| any_bad | output | 1 | Summary flag: a non-normal status was loaded since the last clear |
| overflow | output | 1 | Sticky flag: a write was lost to a full data buffer |

## Verification
Every result of this block is due exactly one rising edge after its strobe. `rd_data` and `any_bad` update on the edge that samples `rd_data_en`. `rd_stat` updates on the edge that samples `rd_stat_en`. `overflow` rises on the edge that samples the discarded write. The bench raises each strobe just after a falling edge and drops it at the next falling edge, and it samples the outputs at that same moment. Every value is therefore read half a cycle after the edge that produced it, and before the next strobe can disturb it.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  localparam int BYTE_W = 8;

  // bit positions inside the status byte (software decodes these)
  localparam int ST_BRK  = 4;
  localparam int ST_FE   = 3;
  localparam int ST_PAR  = 2;
  localparam int ST_NORX = 1;
  localparam int ST_OK   = 0;

  localparam logic [BYTE_W-1:0] STAT_NORX = BYTE_W'(1) << ST_NORX;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              par;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  function automatic logic [BYTE_W-1:0] enc_status(input logic brk,
                                                   input logic fe,
                                                   input logic par);
    logic [BYTE_W-1:0] s;
    s          = '0;
    s[ST_BRK]  = brk;
    s[ST_FE]   = fe;
    s[ST_PAR]  = par;
    s[ST_OK]   = ~(brk | fe | par);
    return s;
  endfunction

endpackage

// File: rtl/rxs_fifo.sv
// Synchronous FIFO with a clear that may coincide with a push: the pushed
// word then becomes the only entry.
module rxs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rp_q, rp_d, wp_q, wp_d, wbase;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CW'(DEPTH));
    do_push = push && (clr || !full);
    do_pop  = pop && !clr && !empty;
    wbase   = clr ? '0 : wp_q;
    rp_d    = clr ? '0 : rp_q;
    wp_d    = wbase;
    cnt_d   = clr ? '0 : cnt_q;
    if (do_pop) begin
      rp_d  = bump(rp_q);
      cnt_d = cnt_d - 1'b1;
    end
    if (do_push) begin
      wp_d  = bump(wbase);
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; entries are only observed while counted
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wbase] <= push_data;
    end
  end

  assign head = mem[rp_q];

endmodule

// File: rtl/rxs_burst_ctl.sv
// Tracks read bursts and the summary flag.
module rxs_burst_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic data_rd,
  input  logic stat_rd,
  input  logic stat_ok,
  output logic stat_clr,
  output logic any_bad
);

  logic open_q, open_d;
  logic bad_q, bad_d;

  always_comb begin
    // a data read opens a new burst unless one is open and no status read
    // arrives alongside it
    stat_clr = data_rd && (!open_q || stat_rd);
    open_d   = open_q;
    bad_d    = bad_q;
    if (data_rd) begin
      open_d = 1'b1;
      bad_d  = (stat_clr ? 1'b0 : bad_q) | ~stat_ok;
    end else if (stat_rd) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      bad_q  <= bad_d;
    end
  end

  assign any_bad = bad_q;

endmodule

// File: rtl/uart_rx_stat_fifo.sv
module uart_rx_stat_fifo
  import uart_rxs_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int STAT_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              wr_brk,
  input  logic              wr_fe,
  input  logic              wr_par,
  input  logic              rd_data_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              rd_stat_en,
  output logic [BYTE_W-1:0] rd_stat,
  output logic              any_bad,
  output logic              overflow
);

  localparam int ENTRY_W = $bits(rx_entry_t);

  rx_entry_t         wr_entry, head_entry;
  logic              data_empty, data_full;
  logic [BYTE_W-1:0] cur_stat, stat_head;
  logic              stat_empty, stat_full, stat_clr;
  logic [BYTE_W-1:0] rd_data_q, rd_data_d, rd_stat_q, rd_stat_d;
  logic              ovf_q, ovf_d;

  // a break is always stored with a zero data field
  always_comb begin
    wr_entry.brk  = wr_brk;
    wr_entry.fe   = wr_fe;
    wr_entry.par  = wr_par;
    wr_entry.data = wr_brk ? '0 : wr_byte;
  end

  rxs_fifo #(
    .WIDTH (ENTRY_W),
    .DEPTH (DATA_DEPTH)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (1'b0),
    .push      (wr_en),
    .push_data (wr_entry),
    .pop       (rd_data_en),
    .head      (head_entry),
    .empty     (data_empty),
    .full      (data_full)
  );

  always_comb begin
    if (data_empty) begin
      cur_stat = STAT_NORX;
    end else begin
      cur_stat = enc_status(head_entry.brk, head_entry.fe, head_entry.par);
    end
  end

  rxs_burst_ctl u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_rd  (rd_data_en),
    .stat_rd  (rd_stat_en),
    .stat_ok  (cur_stat[ST_OK]),
    .stat_clr (stat_clr),
    .any_bad  (any_bad)
  );

  rxs_fifo #(
    .WIDTH (BYTE_W),
    .DEPTH (STAT_DEPTH)
  ) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (stat_clr),
    .push      (rd_data_en),
    .push_data (cur_stat),
    .pop       (rd_stat_en),
    .head      (stat_head),
    .empty     (stat_empty),
    .full      (stat_full)
  );

  // next state of the read registers and the sticky flag
  always_comb begin
    rd_data_d = rd_data_q;
    rd_stat_d = rd_stat_q;
    if (rd_data_en) begin
      rd_data_d = data_empty ? '0 : head_entry.data;
    end
    if (rd_stat_en) begin
      rd_stat_d = stat_empty ? '0 : stat_head;
    end
    ovf_d = ovf_q | (wr_en && data_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_stat_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      rd_data_q <= rd_data_d;
      rd_stat_q <= rd_stat_d;
      ovf_q     <= ovf_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_stat  = rd_stat_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_data_en,
  input logic       rd_stat_en,
  input logic [7:0] rd_data,
  input logic [7:0] rd_stat,
  input logic       any_bad,
  input logic       overflow,
  input logic       data_empty,
  input logic       stat_full
);

  assert_stat_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat != 8'h00) |-> (rd_stat[7:5] == 3'b000 &&
                            rd_stat[0] == (rd_stat[4:1] == 4'h0)));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_en && data_empty) |=> (rd_data == 8'h00));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_en |=> $stable(rd_data));

  assert_stat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat_en |=> $stable(rd_stat));

  assert_full_by_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_full) |-> $past(rd_data_en));

  assert_bad_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_bad) |-> $past(rd_data_en));

  assert_bad_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_en && !rd_data_en) |=> $stable(any_bad));

endmodule

bind uart_rx_stat_fifo rxs_checker u_rxs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_data_en (rd_data_en),
  .rd_stat_en (rd_stat_en),
  .rd_data    (rd_data),
  .rd_stat    (rd_stat),
  .any_bad    (any_bad),
  .overflow   (overflow),
  .data_empty (data_empty),
  .stat_full  (stat_full)
);

// File: tb/sim_uart_rx_stat_fifo.sv
module sim_uart_rx_stat_fifo;

  logic       clk;
  logic       rst_n;
  logic       wr_en, wr_brk, wr_fe, wr_par;
  logic [7:0] wr_byte;
  logic       rd_data_en, rd_stat_en;
  logic [7:0] rd_data, rd_stat;
  logic       any_bad, overflow;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  uart_rx_stat_fifo u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .wr_brk     (wr_brk),
    .wr_fe      (wr_fe),
    .wr_par     (wr_par),
    .rd_data_en (rd_data_en),
    .rd_data    (rd_data),
    .rd_stat_en (rd_stat_en),
    .rd_stat    (rd_stat),
    .any_bad    (any_bad),
    .overflow   (overflow)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_ST = 2'd2;

  // {op, din, flags(brk,fe,par), expected byte, expected any_bad}
  localparam int NV = 21;
  localparam logic [21:0] VEC [NV] = '{
    {OP_WR, 8'h41, 3'b000, 8'h00, 1'b0},
    {OP_WR, 8'h42, 3'b001, 8'h00, 1'b0},
    {OP_WR, 8'h99, 3'b100, 8'h00, 1'b0},  // R2 break data forced to 0
    {OP_WR, 8'h44, 3'b010, 8'h00, 1'b0},
    {OP_RD, 8'h00, 3'b000, 8'h41, 1'b0},  // R4 order, R8 clean
    {OP_RD, 8'h00, 3'b000, 8'h42, 1'b1},  // R8 parity sets summary
    {OP_RD, 8'h00, 3'b000, 8'h00, 1'b1},  // R2
    {OP_ST, 8'h00, 3'b000, 8'h01, 1'b1},  // R1 R5 clean byte
    {OP_ST, 8'h00, 3'b000, 8'h04, 1'b1},  // R1 parity
    {OP_ST, 8'h00, 3'b000, 8'h10, 1'b1},  // R2 break status
    {OP_ST, 8'h00, 3'b000, 8'h00, 1'b1},  // R7 empty status buffer
    {OP_RD, 8'h00, 3'b000, 8'h44, 1'b1},  // R6 new burst, framing bad
    {OP_RD, 8'h00, 3'b000, 8'h00, 1'b1},  // R3 empty data read
    {OP_ST, 8'h00, 3'b000, 8'h08, 1'b1},  // R1 R6 only new burst held
    {OP_ST, 8'h00, 3'b000, 8'h02, 1'b1},  // R3 no-data status
    {OP_WR, 8'h55, 3'b000, 8'h00, 1'b0},
    {OP_RD, 8'h00, 3'b000, 8'h55, 1'b0},  // R6 R8 summary cleared
    {OP_ST, 8'h00, 3'b000, 8'h01, 1'b0},
    {OP_WR, 8'h66, 3'b011, 8'h00, 1'b0},
    {OP_RD, 8'h00, 3'b000, 8'h66, 1'b1},
    {OP_ST, 8'h00, 3'b000, 8'h0C, 1'b1}   // R1 two errors
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] f);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = d; {wr_brk, wr_fe, wr_par} = f;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdd();
    @(negedge clk);
    rd_data_en = 1'b1;
    @(negedge clk);
    rd_data_en = 1'b0;
  endtask

  task automatic rds();
    @(negedge clk);
    rd_stat_en = 1'b1;
    @(negedge clk);
    rd_stat_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_byte = '0; wr_brk = 1'b0; wr_fe = 1'b0;
    wr_par = 1'b0; rd_data_en = 1'b0; rd_stat_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 rd_data after reset", rd_data, 8'h00);
    chk("R9 rd_stat after reset", rd_stat, 8'h00);
    chk("R9 any_bad after reset", {7'd0, any_bad}, 8'h00);
    chk("R9 overflow after reset", {7'd0, overflow}, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      case (v[21:20])
        OP_WR: wr(v[19:12], v[11:9]);
        OP_RD: begin
          rdd();
          chk($sformatf("R5 vector %0d rd_data", i), rd_data, v[8:1]);
          chk($sformatf("R8 vector %0d any_bad", i), {7'd0, any_bad}, {7'd0, v[0]});
        end
        default: begin
          rds();
          chk($sformatf("R5 vector %0d rd_stat", i), rd_stat, v[8:1]);
          chk($sformatf("R8 vector %0d any_bad", i), {7'd0, any_bad}, {7'd0, v[0]});
        end
      endcase
    end

    // R4 fill to 16, then one more write is lost
    for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i), 3'b000);
    chk("R4 overflow before loss", {7'd0, overflow}, 8'h00);
    wr(8'hEE, 3'b000);
    chk("R4 overflow after lost write", {7'd0, overflow}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      rdd();
      chk($sformatf("R4 drain byte %0d", i), rd_data, 8'h10 + 8'(i));
    end
    chk("R8 clean 16-byte burst", {7'd0, any_bad}, 8'h00);
    rdd();
    chk("R4 lost byte absent", rd_data, 8'h00);
    chk("R8 dropped load still counted", {7'd0, any_bad}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      rds();
      chk($sformatf("R5 status %0d of full burst", i), rd_stat, 8'h01);
    end
    rds();
    chk("R5 seventeenth load dropped", rd_stat, 8'h00);
    chk("R4 overflow sticky", {7'd0, overflow}, 8'h01);

    // R9 reset with content present
    wr(8'h77, 3'b000);
    rdd();
    wr(8'h78, 3'b000);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rd_data cleared", rd_data, 8'h00);
    chk("R9 overflow cleared", {7'd0, overflow}, 8'h00);
    chk("R9 any_bad cleared", {7'd0, any_bad}, 8'h00);
    rds();
    chk("R9 status buffer emptied", rd_stat, 8'h00);
    rdd();
    chk("R9 data buffer emptied", rd_data, 8'h00);
    rds();
    chk("R3 status of empty read", rd_stat, 8'h02);

    done = 1;
    finish_run();
  end

endmodule